// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block is the interrupt front end of a small 8-bit microcontroller. It takes one dedicated interrupt pin and a group of general I/O pins, passes them through a clock-domain synchronizer, and watches for the event that a 2-bit sense field selects on the dedicated pin. The four modes are low level, any change, falling edge and rising edge. It also raises a separate request when any monitored I/O pin changes state.

Two enable bits sit in a mask register. A control register holds the sense field. Both are written and read through a simple one-bit-select register port. Every request is gated by the core's global interrupt flag. The highest-priority active request is presented to the core as a vector address. The core pulses an acknowledge when it takes that vector, and the acknowledge clears the stored event of the source being presented. Edge and change events are held as pending flags. The low-level request is never stored and follows the synchronized pin.

Top module: `ext_irq_front`

## Requirements
- R1: After reset, both registers read 0x00, no pending event is held, `irq_req` is 0 and `irq_vec` is 0.
- R2: With `reg_sel`=0 the mask register is addressed. Bit 6 enables the dedicated-pin interrupt, bit 5 enables the pin-change interrupt, and bits 7 and 4..0 always read 0. With `reg_sel`=1 the control register is addressed. Bits 1..0 hold the sense field and bits 7..2 always read 0. A write takes effect on the clock edge where `reg_wr` is high.
- R3: With sense 00, the dedicated-pin request is active while the synchronized pin is low and drops once it is high again. It is never stored, and an acknowledge has no lasting effect on it.
- R4: Sense 01 records any change of the dedicated pin, 10 a high-to-low transition and 11 a low-to-high transition. A pin change set up before clock edge k sets the pending flag at edge k+2, and the request is visible right after that edge. A level held for two or more clocks is always seen.
- R5: A source presents a request only while its enable bit and `gie` are both 1. An event is recorded only while its enable bit is 1. A pending flag survives periods with `gie` low.
- R6: With the pin-change enable set, a change on any bit of `io_pins` sets the pin-change pending flag, using the same two-edge delay as R4.
- R7: `irq_vec` is 1 for the dedicated-pin request, 2 for the pin-change request and 0 when none is active. `irq_req` is 1 exactly when `irq_vec` is non-zero.
- R8: When both requests are active, the dedicated-pin request is presented first.
- R9: `irq_ack` clears only the pending flag of the source currently presented. An event arriving in the same cycle as the acknowledge keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the mask register, 1 the control register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| int_pin | input | 1 | Dedicated interrupt pin, asynchronous |
| io_pins | input | N_IO | Monitored I/O pins, asynchronous |
| gie | input | 1 | Global interrupt enable from the core |
| irq_ack | input | 1 | Core took the presented vector |
| irq_req | output | 1 | A request is presented |
| irq_vec | output | VEC_W | Vector address of the presented request |

## Verification
A stuck or lost pending flag shows as a vector that refuses to clear after an acknowledge, or as a missing vector three clock edges after a pin edge. A synchronizer stage that is off by one moves every request by one cycle. Every output is compared every cycle against an independent model, so such a shift is caught at the first event after the fault. Wrong register decode shows on the next readback, or as a request that appears with the wrong enable or sense setting.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  localparam int EXT_EN_BIT = 6;
  localparam int PC_EN_BIT  = 5;
  localparam int EXT_VECTOR = 1;
  localparam int PC_VECTOR  = 2;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int W     = 6,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] stage_q [DEPTH];
  logic [W-1:0] prev_q;

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_stage
      logic [W-1:0] stage_d;
      if (gi == 0) begin : g_first
        assign stage_d = din;
      end else begin : g_next
        assign stage_d = stage_q[gi-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[gi] <= '0;
        else        stage_q[gi] <= stage_d;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stage_q[DEPTH-1];
  end

  assign cur  = stage_q[DEPTH-1];
  assign prev = prev_q;

  // R4
  sync_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> prev == $past(cur));
endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
  import ext_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       sel,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       en_ext,
  output logic       en_pc,
  output sense_e     sense
);
  logic       en_ext_q, en_ext_d;
  logic       en_pc_q, en_pc_d;
  logic [1:0] sense_q, sense_d;
  logic       wr_mask, wr_ctrl;

  assign wr_mask = wr_en && !sel;
  assign wr_ctrl = wr_en && sel;

  always_comb begin
    en_ext_d = en_ext_q;
    en_pc_d  = en_pc_q;
    sense_d  = sense_q;
    if (wr_mask) begin
      en_ext_d = wdata[EXT_EN_BIT];
      en_pc_d  = wdata[PC_EN_BIT];
    end
    if (wr_ctrl) sense_d = wdata[1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_ext_q <= 1'b0;
      en_pc_q  <= 1'b0;
      sense_q  <= 2'b00;
    end else begin
      en_ext_q <= en_ext_d;
      en_pc_q  <= en_pc_d;
      sense_q  <= sense_d;
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (!sel) begin
      rdata[EXT_EN_BIT] = en_ext_q;
      rdata[PC_EN_BIT]  = en_pc_q;
    end else begin
      rdata[1:0] = sense_q;
    end
  end

  assign en_ext = en_ext_q;
  assign en_pc  = en_pc_q;
  assign sense  = sense_e'(sense_q);

  // R2
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> en_ext == $past(wdata[EXT_EN_BIT]) && en_pc == $past(wdata[PC_EN_BIT]));
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import ext_irq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  sense_e sense,
  input  logic   en,
  input  logic   cur,
  input  logic   prev,
  input  logic   clr,
  output logic   level_act,
  output logic   pend
);
  logic evt;
  logic pend_q, pend_d;

  always_comb begin
    unique case (sense)
      SENSE_ANY:  evt = cur ^ prev;
      SENSE_FALL: evt = prev & ~cur;
      SENSE_RISE: evt = ~prev & cur;
      default:    evt = 1'b0;
    endcase
  end

  assign level_act = (sense == SENSE_LOW) && !cur;

  always_comb begin
    pend_d = pend_q;
    if (clr) pend_d = 1'b0;
    if (en && evt) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;

  // R9
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(en && evt)) |=> !pend);

  // R3
  level_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sense == SENSE_LOW && !pend) |=> !pend);
endmodule

// File: rtl/ext_irq_front.sv
module ext_irq_front
  import ext_irq_pkg::*;
#(
  parameter int N_IO       = 5,
  parameter int VEC_W      = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             int_pin,
  input  logic [N_IO-1:0]  io_pins,
  input  logic             gie,
  input  logic             irq_ack,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec
);
  localparam int SW = N_IO + 1;

  logic          rst_a, rst_b;
  logic          rst_i;
  logic [SW-1:0] s_cur, s_prev;
  logic          en_ext, en_pc;
  sense_e        sense;
  logic          lvl_act, ext_pend;
  logic          ext_req, pc_req;
  logic          clr_ext, clr_pc;
  logic          pc_evt;
  logic          pc_pend_q, pc_pend_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_a <= 1'b0;
      rst_b <= 1'b0;
    end else begin
      rst_a <= 1'b1;
      rst_b <= rst_a;
    end
  end
  assign rst_i = rst_b;

  ext_irq_sync #(.W(SW), .DEPTH(SYNC_DEPTH)) i_sync (
    .clk (clk),
    .rst_n (rst_i),
    .din ({io_pins, int_pin}),
    .cur (s_cur),
    .prev (s_prev)
  );

  ext_irq_regs i_regs (
    .clk (clk),
    .rst_n (rst_i),
    .wr_en (reg_wr),
    .sel (reg_sel),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .en_ext (en_ext),
    .en_pc (en_pc),
    .sense (sense)
  );

  ext_irq_sense i_sense (
    .clk (clk),
    .rst_n (rst_i),
    .sense (sense),
    .en (en_ext),
    .cur (s_cur[0]),
    .prev (s_prev[0]),
    .clr (clr_ext),
    .level_act (lvl_act),
    .pend (ext_pend)
  );

  assign pc_evt = |(s_cur[SW-1:1] ^ s_prev[SW-1:1]);

  always_comb begin
    pc_pend_d = pc_pend_q;
    if (clr_pc) pc_pend_d = 1'b0;
    if (en_pc && pc_evt) pc_pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) pc_pend_q <= 1'b0;
    else        pc_pend_q <= pc_pend_d;
  end

  assign ext_req = gie && en_ext && (ext_pend || lvl_act);
  assign pc_req  = gie && en_pc && pc_pend_q;
  assign clr_ext = irq_ack && ext_req;
  assign clr_pc  = irq_ack && !ext_req && pc_req;

  always_comb begin
    irq_vec = '0;
    if (ext_req)     irq_vec = VEC_W'(EXT_VECTOR);
    else if (pc_req) irq_vec = VEC_W'(PC_VECTOR);
  end
  assign irq_req = ext_req || pc_req;

  // R7
  req_vec_match_chk: assert property (@(posedge clk) disable iff (!rst_i)
    irq_req == (irq_vec != '0));

  // R5
  no_req_without_gie_chk: assert property (@(posedge clk) disable iff (!rst_i)
    !gie |-> !irq_req);

  // R8
  ext_first_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (ext_pend && en_ext && gie) |-> irq_vec == VEC_W'(EXT_VECTOR));

  // R9
  pc_ack_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (irq_ack && irq_vec == VEC_W'(PC_VECTOR) && !(en_pc && pc_evt)) |=> !pc_pend_q);
endmodule

// File: tb/test_ext_irq_front.sv
module test_ext_irq_front;
  localparam int N_IO  = 5;
  localparam int VEC_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             reg_wr = 1'b0;
  logic             reg_sel = 1'b0;
  logic [7:0]       reg_wdata = 8'h00;
  logic [7:0]       reg_rdata;
  logic             int_pin = 1'b0;
  logic [N_IO-1:0]  io_pins = '0;
  logic             gie = 1'b0;
  logic             irq_ack = 1'b0;
  logic             irq_req;
  logic [VEC_W-1:0] irq_vec;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ext_irq_front #(.N_IO(N_IO), .VEC_W(VEC_W)) i_ext_irq_front (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .int_pin(int_pin),
    .io_pins(io_pins), .gie(gie), .irq_ack(irq_ack),
    .irq_req(irq_req), .irq_vec(irq_vec)
  );

  // reference model, built from the requirements
  logic mr1, mr2;
  logic m1, m2, m3;
  logic [N_IO-1:0] p1, p2, p3;
  logic me, mp;
  logic [1:0] ms;
  logic epend, ppend;

  function automatic logic f_ext_req();
    return gie && me && (epend || (ms == 2'b00 && !m2));
  endfunction
  function automatic logic f_pc_req();
    return gie && mp && ppend;
  endfunction
  function automatic logic [VEC_W-1:0] f_vec();
    if (f_ext_req()) return 1;
    if (f_pc_req())  return 2;
    return 0;
  endfunction
  function automatic logic [7:0] f_rdata();
    if (!reg_sel) return {1'b0, me, mp, 5'b0};
    return {6'b0, ms};
  endfunction
  function automatic logic f_ext_evt();
    case (ms)
      2'b01:   return m2 ^ m3;
      2'b10:   return m3 & ~m2;
      2'b11:   return ~m3 & m2;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr1 <= 0; mr2 <= 0;
    end else begin
      mr1 <= 1; mr2 <= mr1;
    end
  end

  always @(posedge clk or negedge mr2) begin
    if (!mr2) begin
      m1 <= 0; m2 <= 0; m3 <= 0; p1 <= '0; p2 <= '0; p3 <= '0;
      me <= 0; mp <= 0; ms <= 0; epend <= 0; ppend <= 0;
    end else begin
      logic ce, cp;
      ce = irq_ack && f_ext_req();
      cp = irq_ack && !f_ext_req() && f_pc_req();
      m1 <= int_pin; m2 <= m1; m3 <= m2;
      p1 <= io_pins; p2 <= p1; p3 <= p2;
      if (reg_wr && !reg_sel) begin me <= reg_wdata[6]; mp <= reg_wdata[5]; end
      if (reg_wr && reg_sel) ms <= reg_wdata[1:0];
      epend <= (epend && !ce) || (me && f_ext_evt());
      ppend <= (ppend && !cp) || (mp && |(p2 ^ p3));
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R5 R3 R4 R6 irq_req", {7'b0, irq_req}, {7'b0, f_ext_req() || f_pc_req()});
    chk("R7 R8 R9 irq_vec", {4'b0, irq_vec}, {4'b0, f_vec()});
    chk("R2 reg_rdata", reg_rdata, f_rdata());
  endtask

  // one cycle: check at the negedge, then drive the next inputs
  task automatic step(input logic wr, input logic sel, input logic [7:0] wd,
                      input logic ip, input logic [N_IO-1:0] io,
                      input logic g, input logic ack);
    @(negedge clk);
    check_all();
    reg_wr = wr; reg_sel = sel; reg_wdata = wd;
    int_pin = ip; io_pins = io; gie = g; irq_ack = ack;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, reg_sel, 8'h00, int_pin, io_pins, gie, 0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 mask after reset", reg_rdata, 8'h00);
    chk("R1 irq_req after reset", {7'b0, irq_req}, 8'h00);
    chk("R1 irq_vec after reset", {4'b0, irq_vec}, 8'h00);
    reg_sel = 1'b1;
    #1 chk("R1 ctrl after reset", reg_rdata, 8'h00);
    // R2 reserved bits
    step(1, 0, 8'hFF, 0, '0, 0, 0);
    step(1, 1, 8'hFF, 0, '0, 0, 0);
    step(0, 0, 8'h00, 0, '0, 0, 0);
    #1 chk("R2 mask readback", reg_rdata, 8'h60);
    step(0, 1, 8'h00, 0, '0, 0, 0);
    #1 chk("R2 ctrl readback", reg_rdata, 8'h03);
    // R4 falling edge, two-clock pulse: request three negedges after drive
    step(1, 1, 8'h02, 1, '0, 1, 0);
    idle(4);
    step(0, 1, 8'h00, 0, '0, 1, 0);
    step(0, 1, 8'h00, 0, '0, 1, 0);
    step(0, 1, 8'h00, 1, '0, 1, 0);
    @(negedge clk);
    chk("R4 falling pulse request", {4'b0, irq_vec}, 8'h01);
    // R8 priority and R9 ack: add pin change
    step(0, 1, 8'h00, 1, 5'b00100, 1, 0);
    idle(4);
    @(negedge clk);
    chk("R8 ext first", {4'b0, irq_vec}, 8'h01);
    step(0, 1, 8'h00, 1, 5'b00100, 1, 1);
    @(negedge clk);
    chk("R9 pc after ext ack", {4'b0, irq_vec}, 8'h02);
    step(0, 1, 8'h00, 1, 5'b00100, 1, 1);
    @(negedge clk);
    chk("R9 none after both acks", {4'b0, irq_vec}, 8'h00);
    // R3 low level, not stored; ack does not stick
    step(1, 1, 8'h00, 0, 5'b00100, 1, 0);
    idle(3);
    @(negedge clk);
    chk("R3 level active", {7'b0, irq_req}, 8'h01);
    step(0, 1, 8'h00, 0, 5'b00100, 1, 1);
    @(negedge clk);
    chk("R3 level after ack", {7'b0, irq_req}, 8'h01);
    step(0, 1, 8'h00, 1, 5'b00100, 1, 0);
    idle(3);
    @(negedge clk);
    chk("R3 level released", {7'b0, irq_req}, 8'h00);
    // R5 gie low hides, pending kept
    step(1, 1, 8'h03, 1, 5'b00100, 0, 0);
    step(0, 1, 8'h00, 0, 5'b00100, 0, 0);
    step(0, 1, 8'h00, 1, 5'b00100, 0, 0);
    idle(4);
    @(negedge clk);
    chk("R5 hidden by gie", {7'b0, irq_req}, 8'h00);
    step(0, 1, 8'h00, 1, 5'b00100, 1, 0);
    @(negedge clk);
    chk("R5 pending kept", {4'b0, irq_vec}, 8'h01);
    // random phase, model checked every cycle (R3 R4 R5 R6 R7 R8 R9)
    for (int i = 0; i < 4000; i++) begin
      logic wr, sel, ip, g, ack;
      logic [7:0] wd;
      logic [N_IO-1:0] io;
      wr  = ($urandom % 16) == 0;
      sel = $urandom % 2;
      wd  = $urandom;
      ip  = (($urandom % 4) == 0) ? ~int_pin : int_pin;
      io  = io_pins;
      if (($urandom % 5) == 0) io[$urandom % N_IO] = ~io[$urandom % N_IO];
      g   = ($urandom % 8) != 0;
      ack = ($urandom % 5) == 0;
      step(wr, sel, wd, ip, io, g, ack);
    end
    @(negedge clk);
    check_all();
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule